// File: doc/BRIEF.md
# Stopwatch Mode Control FSM

This block sequences a two-mode stopwatch. In clock mode the time counter counts up from zero. In timer mode it counts down from a loaded preset. The block takes three debounced push-button levels (start/stop, mode and lap/load), a synchronous reset and a reached-zero flag from the counter. It drives the count-enable and count-direction levels, a clear request, a one-cycle lap-capture strobe and a one-cycle preset-load strobe, together with the index of the preset to load.

Every button is edge-detected, so a button that is held down produces one action only. The lap/load button has two meanings. In clock mode it copies the running time into a lap register, whether the clock is running or stopped. In timer mode it loads the next preset, and it does so only while the timer is stopped. Mode changes are refused while counting. A countdown halts by itself when the counter reports zero.

Top module: `sw_ctrl`

## Requirements
- R1: While `rst` is sampled high, the next edge gives `cnt_en`=0, `cnt_up`=1 (clock mode), `preset_idx`=0, `lap_latch`=0, `preset_load`=0 and `clr_time`=1. `clr_time` returns to 0 on the first edge that samples `rst` low.
- R2: A press of `start_n` is a falling level (1 to 0), because the input is active low. Each press toggles `cnt_en` at the edge that samples it. Holding the button low has no further effect.
- R3: While stopped, a rising level on `mode_btn` toggles the mode at the sampling edge. `cnt_up` is 1 in clock mode and 0 in timer mode.
- R4: While `cnt_en`=1, presses of `mode_btn` are ignored. `cnt_up` does not change while running, and it does not change after the stop either.
- R5: In clock mode, a rising level on `lap_btn` gives `lap_latch`=1 for exactly one cycle, whether the clock is running or stopped. `preset_load` stays 0.
- R6: In timer mode with the timer stopped, a rising level on `lap_btn` gives `preset_load`=1 for one cycle. During that cycle `preset_idx` names the entry to load. On the next edge `preset_idx` advances by one, modulo 64 (6 bits), so 63 wraps to 0.
- R7: In timer mode with the timer running, `lap_btn` presses produce neither `preset_load` nor `lap_latch`, and `preset_idx` stays unchanged.
- R8: In timer mode while running, `at_zero`=1 clears `cnt_en` at the next edge and keeps timer mode. In clock mode `at_zero` has no effect.
- R9: A `lap_btn` held high for several cycles produces only one strobe.
- R10: When stopped, a start press and a mode press in the same cycle start the counter in the present mode. The mode press is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Debounced start/stop button, active low |
| mode_btn | input | 1 | Debounced mode button, active high |
| lap_btn | input | 1 | Debounced lap/load button, active high |
| at_zero | input | 1 | Counter reports a value of zero |
| cnt_en | output | 1 | Counter enable (running) |
| cnt_up | output | 1 | Count direction: 1 up (clock), 0 down (timer) |
| clr_time | output | 1 | Clear request for counter and lap display |
| lap_latch | output | 1 | One-cycle lap capture strobe |
| preset_load | output | 1 | One-cycle preset load strobe |
| preset_idx | output | 6 | Index of the preset entry to load |

## Verification
The bench loads presets many times over, more than 64 in a row, and compares every strobe against an index it keeps itself. A design that advanced the index before the strobe would load the wrong entry, and one that failed to wrap would leave the range. Held buttons catch a level-sensitive design, which would toggle the run state or fire strobes on every cycle. Mode presses while running, a lap press during a countdown, and a start press together with a mode press expose a design that changes direction mid-count, loads a preset while counting, or lets mode win the race. Holding `at_zero` in clock mode catches a design that wrongly halts the clock.

// File: rtl/sw_pkg.sv
package sw_pkg;
  // bit 1: timer mode, bit 0: running
  typedef enum logic [1:0] {
    ST_CLK_STOP = 2'b00,
    ST_CLK_RUN  = 2'b01,
    ST_TMR_STOP = 2'b10,
    ST_TMR_RUN  = 2'b11
  } sw_state_e;

  function automatic logic st_running(sw_state_e s);
    return s[0];
  endfunction

  function automatic logic st_timer(sw_state_e s);
    return s[1];
  endfunction
endpackage

// File: rtl/sw_edge.sv
module sw_edge #(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic press
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE_LEVEL;
    else     prev_q <= lvl;
  end

  generate
    if (IDLE_LEVEL) begin : g_act_low
      assign press = prev_q & ~lvl;
    end else begin : g_act_high
      assign press = ~prev_q & lvl;
    end
  endgenerate

  AST_PRESS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    press |=> !press); // R9
endmodule

// File: rtl/sw_preset_idx.sv
module sw_preset_idx #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  function automatic logic [IDX_W-1:0] step(logic [IDX_W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= step(idx);
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    adv |=> idx == $past(idx) + 1'b1); // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(idx)); // R7
endmodule

// File: rtl/sw_fsm.sv
module sw_fsm
  import sw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start_ev,
  input  logic      mode_ev,
  input  logic      lap_ev,
  input  logic      at_zero,
  output sw_state_e state,
  output logic      lap_latch,
  output logic      preset_load
);
  sw_state_e nxt;
  logic      lap_in_clock;
  logic      load_in_timer;

  assign lap_in_clock  = lap_ev & ~st_timer(state);
  assign load_in_timer = lap_ev & (state == ST_TMR_STOP);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_CLK_STOP: if (start_ev) nxt = ST_CLK_RUN;
                   else if (mode_ev) nxt = ST_TMR_STOP;
      ST_CLK_RUN:  if (start_ev) nxt = ST_CLK_STOP;
      ST_TMR_STOP: if (start_ev) nxt = ST_TMR_RUN;
                   else if (mode_ev) nxt = ST_CLK_STOP;
      ST_TMR_RUN:  if (start_ev || at_zero) nxt = ST_TMR_STOP;
      default:     nxt = ST_CLK_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_CLK_STOP;
      lap_latch   <= 1'b0;
      preset_load <= 1'b0;
    end else begin
      state       <= nxt;
      lap_latch   <= lap_in_clock;
      preset_load <= load_in_timer;
    end
  end

  AST_START_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> st_running(state) != $past(st_running(state))); // R2
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    st_running(state) |=> st_timer(state) == $past(st_timer(state))); // R4
  AST_ZERO_HALTS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TMR_RUN && at_zero) |=> state == ST_TMR_STOP); // R8
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(lap_latch && preset_load)); // R5
  AST_LOAD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    preset_load |-> $past(state) == ST_TMR_STOP); // R6
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             mode_btn,
  input  logic             lap_btn,
  input  logic             at_zero,
  output logic             cnt_en,
  output logic             cnt_up,
  output logic             clr_time,
  output logic             lap_latch,
  output logic             preset_load,
  output logic [IDX_W-1:0] preset_idx
);
  logic      start_ev, mode_ev, lap_ev;
  sw_state_e state;

  sw_edge #(.IDLE_LEVEL(1'b1)) u_start (
    .clk(clk), .rst(rst), .lvl(start_n), .press(start_ev));
  sw_edge #(.IDLE_LEVEL(1'b0)) u_mode (
    .clk(clk), .rst(rst), .lvl(mode_btn), .press(mode_ev));
  sw_edge #(.IDLE_LEVEL(1'b0)) u_lap (
    .clk(clk), .rst(rst), .lvl(lap_btn), .press(lap_ev));

  sw_fsm u_fsm (
    .clk(clk), .rst(rst),
    .start_ev(start_ev), .mode_ev(mode_ev), .lap_ev(lap_ev),
    .at_zero(at_zero),
    .state(state), .lap_latch(lap_latch), .preset_load(preset_load));

  sw_preset_idx #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst(rst), .adv(preset_load), .idx(preset_idx));

  always_ff @(posedge clk) clr_time <= rst;

  assign cnt_en = st_running(state);
  assign cnt_up = ~st_timer(state);

  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> clr_time && !cnt_en && cnt_up); // R1
endmodule

// File: tb/sw_ctrl_bench.sv
module sw_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_n = 1'b1, mode_btn = 1'b0, lap_btn = 1'b0, at_zero = 1'b0;
  logic cnt_en, cnt_up, clr_time, lap_latch, preset_load;
  logic [5:0] preset_idx;
  int checks = 0, failures = 0;
  int exp_idx = 0;

  always #5 clk = ~clk;

  sw_ctrl u_sw_ctrl (
    .clk(clk), .rst(rst), .start_n(start_n), .mode_btn(mode_btn),
    .lap_btn(lap_btn), .at_zero(at_zero), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .clr_time(clr_time), .lap_latch(lap_latch), .preset_load(preset_load),
    .preset_idx(preset_idx));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // drive at falling edge, then look 1 ns after the next rising edge
  task automatic cyc(logic s_n, logic m, logic l, logic z);
    @(negedge clk);
    start_n = s_n; mode_btn = m; lap_btn = l; at_zero = z;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic toggle_run();
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    idle();
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    idle(); idle();
    chk("R1 clr_time", clr_time, 1); chk("R1 cnt_en", cnt_en, 0);
    chk("R1 cnt_up", cnt_up, 1); chk("R1 idx", preset_idx, 0);
    chk("R1 lap", lap_latch, 0); chk("R1 load", preset_load, 0);
    @(negedge clk); rst = 1'b0;
    idle();
    chk("R1 clr_time released", clr_time, 0);

    // R2 toggle, held button
    cyc(1'b0, 1'b0, 1'b0, 1'b0); chk("R2 start", cnt_en, 1);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0); chk("R2 held", cnt_en, 1);
    end
    idle(); chk("R2 release", cnt_en, 1);
    cyc(1'b0, 1'b0, 1'b0, 1'b0); chk("R2 stop", cnt_en, 0);
    idle();

    // R5 lap while stopped, R9 held
    cyc(1'b1, 1'b0, 1'b1, 1'b0); chk("R5 lap stopped", lap_latch, 1);
    chk("R5 no load", preset_load, 0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0); chk("R9 lap held", lap_latch, 0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0); chk("R9 lap held2", lap_latch, 0);
    idle();
    // R5 lap while running
    toggle_run(); chk("R5 running", cnt_en, 1);
    cyc(1'b1, 1'b0, 1'b1, 1'b0); chk("R5 lap running", lap_latch, 1);
    chk("R5 no load running", preset_load, 0);
    idle(); chk("R5 one cycle", lap_latch, 0);

    // R4 mode ignored while running
    cyc(1'b1, 1'b1, 1'b0, 1'b0); chk("R4 mode while run", cnt_up, 1);
    idle();
    // R8 at_zero ignored in clock mode
    cyc(1'b1, 1'b0, 1'b0, 1'b1); chk("R8 zero clock", cnt_en, 1);
    idle(); chk("R8 zero clock2", cnt_en, 1);
    toggle_run(); chk("R4 stop keeps mode", cnt_up, 1);
    chk("R4 stopped", cnt_en, 0);

    // R3 enter timer mode
    cyc(1'b1, 1'b1, 1'b0, 1'b0); chk("R3 to timer", cnt_up, 0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0); chk("R3 held mode", cnt_up, 0);
    idle();

    // R6 preset sweep with wrap
    for (int i = 0; i < 70; i++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b0);
      chk("R6 load pulse", preset_load, 1);
      chk("R6 idx during load", preset_idx, exp_idx);
      chk("R6 no lap in timer", lap_latch, 0);
      exp_idx = (exp_idx + 1) % 64;
      idle();
      chk("R6 pulse ends", preset_load, 0);
      chk("R6 idx advanced", preset_idx, exp_idx);
    end

    // R7 lap while timer runs
    toggle_run(); chk("R7 running", cnt_en, 1); chk("R7 down", cnt_up, 0);
    cyc(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 no load", preset_load, 0); chk("R7 no lap", lap_latch, 0);
    idle(); chk("R7 idx kept", preset_idx, exp_idx);
    cyc(1'b1, 1'b1, 1'b0, 1'b0); chk("R4 timer mode held", cnt_up, 0);
    idle();

    // R8 countdown reaches zero
    cyc(1'b1, 1'b0, 1'b0, 1'b1); chk("R8 halt", cnt_en, 0);
    chk("R8 stays timer", cnt_up, 0);
    idle();

    // R10 start and mode together
    cyc(1'b0, 1'b1, 1'b0, 1'b0); chk("R10 started", cnt_en, 1);
    chk("R10 mode dropped", cnt_up, 0);
    idle();
    toggle_run(); chk("R10 stopped", cnt_en, 0); chk("R10 still timer", cnt_up, 0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0); chk("R3 back to clock", cnt_up, 1);
    idle();

    // R1 reset during timer run
    cyc(1'b1, 1'b1, 1'b0, 1'b0); idle(); toggle_run();
    chk("R1 pre run", cnt_en, 1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 run cleared", cnt_en, 0); chk("R1 clock mode", cnt_up, 1);
    chk("R1 idx cleared", preset_idx, 0); chk("R1 clear req", clr_time, 1);
    @(negedge clk); rst = 1'b0;
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule